// File: doc/BRIEF.md
# Serial Keyboard Protocol Engine

This block is the keyboard side of a serial keyboard link. Raw scancode events from a key-matrix scanner arrive as a one-cycle strobe with an 8-bit code. The engine maps each code into the keyboard's own code set through a lookup table and hands the result to a receive byte FIFO through a push interface. Two small state machines sit in front of the table. One gives the Caps Lock and Num Lock keys toggle behaviour by dropping selected press and release events. The other lets a prefix code switch the next lookup to an alternate table.

Command bytes sent by the host to the keyboard arrive on a second strobe. A parser answers the reset and layout-query commands with two-byte responses pushed into the same FIFO. After a set-LEDs command it swallows the following byte. The FIFO itself sits outside the block and reports its full state back. Any byte that falls due while the FIFO is full is discarded. The table contents are a computed placeholder that a real code set can replace.

Top module: `kbd_proto_engine`

## Requirements
- R1: After reset `pushValid` is low, the extended mode, both lock modes and the LED-argument flag are cleared, and no byte is pushed until an input strobe arrives.
- R2: A scancode strobe with code c (not 0xE0 and not a lock code) pushes exactly one byte in the following cycle: bit 7 copies c[7] (the release flag), and bits 6:0 come from the normal table, which maps index i = c[6:0] to i XOR 0x2A for i < 0x70.
- R3: A table entry of 0 produces no push: normal-table indices 0x70 to 0x7F and 0x2A, and alternate-table indices that are even or equal to 0x6F.
- R4: Code 0xE0 pushes nothing and sets the extended mode. The next code that reaches the table is looked up in the alternate table, which maps an odd index i to (i + 0x11) mod 128. The mode then clears, so the code after that uses the normal table again.
- R5: Caps Lock press (0x3A) and release (0xBA) each flip their own bit of a 2-bit mode, press on bit 0 and release on bit 1. A press that leaves the mode at 2 is dropped, and so is a release that leaves it at 3. From reset the sequence press, release, press, release pushes only the first press and the last release.
- R6: Num Lock press (0x45) and release (0xC5) follow the same rule with their own independent 2-bit mode.
- R7: Host command 0x01 pushes 0xFF in the next cycle and the type code 0x04 in the cycle after.
- R8: Host command 0x07 pushes 0xFE in the next cycle and the layout byte 0x00 in the cycle after.
- R9: Host command 0x0E pushes nothing. The next host byte, whatever its value, is then consumed with no push and no other effect.
- R10: Any other host byte that arrives while no LED argument is expected is ignored and pushes nothing.
- R11: A byte that falls due in a cycle where `queueFull` is high is discarded: `pushValid` stays low in the next cycle and the byte is never pushed later. This holds for each byte of a two-byte response separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyValid | input | 1 | Scancode strobe, one cycle per event |
| keyCode | input | 8 | Raw scancode; bit 7 marks a release |
| hostValid | input | 1 | Host command byte strobe |
| hostByte | input | 8 | Command or argument byte from the host |
| queueFull | input | 1 | Receive FIFO is full |
| pushValid | output | 1 | Push strobe into the receive FIFO |
| pushData | output | 8 | Byte being pushed |

## Verification
The checks assume that the scancode strobe and the host strobe are never high in the same cycle. They also assume that both strobes stay low in the cycle after a reset or layout command, while the response's second byte is being emitted. The checker states both of these as properties over the inputs and the engine's pending-response state. The bench meets them by giving every event a single strobe cycle followed by at least three idle cycles. It sweeps every non-special scancode, every alternate-table index behind a prefix, the lock sequences and the host commands, and it raises `queueFull` both for whole events and for the second response byte alone.

// File: rtl/kbd_proto_pkg.sv
package kbd_proto_pkg;
  localparam int CODE_W = 8;
  localparam int IDX_W  = CODE_W - 1;

  localparam logic [CODE_W-1:0] KEY_PREFIX   = 8'hE0;
  localparam logic [CODE_W-1:0] KEY_CAPS_DN  = 8'h3A;
  localparam logic [CODE_W-1:0] KEY_CAPS_UP  = 8'hBA;
  localparam logic [CODE_W-1:0] KEY_NUM_DN   = 8'h45;
  localparam logic [CODE_W-1:0] KEY_NUM_UP   = 8'hC5;

  localparam logic [CODE_W-1:0] HOST_RESET   = 8'h01;
  localparam logic [CODE_W-1:0] HOST_LAYOUT  = 8'h07;
  localparam logic [CODE_W-1:0] HOST_LEDS    = 8'h0E;

  localparam logic [CODE_W-1:0] RSP_RESET_HDR  = 8'hFF;
  localparam logic [CODE_W-1:0] RSP_LAYOUT_HDR = 8'hFE;

  typedef enum logic [1:0] {
    SEL_RESET_HDR,
    SEL_TYPE_ID,
    SEL_LAYOUT_HDR,
    SEL_LAYOUT_ID
  } rspSel_t;

  typedef struct packed {
    logic    keyPush;
    logic    extSel;
    logic    rspPush;
    rspSel_t rspSel;
  } dpStrobe_t;
endpackage

// File: rtl/kbd_proto_dp.sv
module kbd_proto_dp
  import kbd_proto_pkg::*;
#(
  parameter logic [CODE_W-1:0] TYPE_ID   = 8'h04,
  parameter logic [CODE_W-1:0] LAYOUT_ID = 8'h00,
  parameter logic [IDX_W-1:0]  NORM_MIX  = 7'h2A,
  parameter logic [IDX_W-1:0]  NORM_LIM  = 7'h70,
  parameter logic [IDX_W-1:0]  EXT_STEP  = 7'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CODE_W-1:0] keyCode,
  input  logic              queueFull,
  output logic              pushValid,
  output logic [CODE_W-1:0] pushData
);
  function automatic logic [IDX_W-1:0] normEntry(input logic [IDX_W-1:0] idx);
    if (idx >= NORM_LIM) return '0;
    return idx ^ NORM_MIX;
  endfunction

  function automatic logic [IDX_W-1:0] extEntry(input logic [IDX_W-1:0] idx);
    if (!idx[0]) return '0;
    return idx + EXT_STEP;
  endfunction

  logic [IDX_W-1:0]  tblOut;
  logic [CODE_W-1:0] rspByte;
  logic [CODE_W-1:0] nextByte;
  logic              haveByte;

  always_comb begin
    tblOut = strobe.extSel ? extEntry(keyCode[IDX_W-1:0])
                           : normEntry(keyCode[IDX_W-1:0]);
    unique case (strobe.rspSel)
      SEL_RESET_HDR:  rspByte = RSP_RESET_HDR;
      SEL_TYPE_ID:    rspByte = TYPE_ID;
      SEL_LAYOUT_HDR: rspByte = RSP_LAYOUT_HDR;
      default:        rspByte = LAYOUT_ID;
    endcase
    haveByte = strobe.rspPush | (strobe.keyPush && (tblOut != '0));
    nextByte = strobe.rspPush ? rspByte : {keyCode[CODE_W-1], tblOut};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pushValid <= 1'b0;
      pushData  <= '0;
    end else begin
      pushValid <= haveByte & ~queueFull;
      if (haveByte) pushData <= nextByte;
    end
  end
endmodule

// File: rtl/kbd_proto_ctrl.sv
module kbd_proto_ctrl
  import kbd_proto_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyValid,
  input  logic [CODE_W-1:0] keyCode,
  input  logic              hostValid,
  input  logic [CODE_W-1:0] hostByte,
  output dpStrobe_t         strobe,
  output logic              tailPending,
  output logic              ledArmed
);
  logic       extMode, extModeNext;
  logic [1:0] capsMode, capsNext;
  logic [1:0] numMode, numNext;
  logic       ledNext, tailNext;
  rspSel_t    tailSel, tailSelNext;
  logic       passKey;

  always_comb begin
    strobe      = '0;
    extModeNext = extMode;
    capsNext    = capsMode;
    numNext     = numMode;
    ledNext     = ledArmed;
    tailNext    = 1'b0;
    tailSelNext = tailSel;
    passKey     = 1'b0;
    if (tailPending) begin
      strobe.rspPush = 1'b1;
      strobe.rspSel  = tailSel;
    end else if (keyValid) begin
      passKey = 1'b1;
      unique case (keyCode)
        KEY_PREFIX: begin
          extModeNext = 1'b1;
          passKey     = 1'b0;
        end
        KEY_CAPS_DN: begin
          capsNext = capsMode ^ 2'b01;
          passKey  = (capsNext != 2'b10);
        end
        KEY_CAPS_UP: begin
          capsNext = capsMode ^ 2'b10;
          passKey  = (capsNext != 2'b11);
        end
        KEY_NUM_DN: begin
          numNext = numMode ^ 2'b01;
          passKey = (numNext != 2'b10);
        end
        KEY_NUM_UP: begin
          numNext = numMode ^ 2'b10;
          passKey = (numNext != 2'b11);
        end
        default: ;
      endcase
      if (passKey) begin
        strobe.keyPush = 1'b1;
        strobe.extSel  = extMode;
        extModeNext    = 1'b0;
      end
    end else if (hostValid) begin
      if (ledArmed) begin
        ledNext = 1'b0;
      end else begin
        unique case (hostByte)
          HOST_RESET: begin
            strobe.rspPush = 1'b1;
            strobe.rspSel  = SEL_RESET_HDR;
            tailNext       = 1'b1;
            tailSelNext    = SEL_TYPE_ID;
          end
          HOST_LAYOUT: begin
            strobe.rspPush = 1'b1;
            strobe.rspSel  = SEL_LAYOUT_HDR;
            tailNext       = 1'b1;
            tailSelNext    = SEL_LAYOUT_ID;
          end
          HOST_LEDS: ledNext = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extMode     <= 1'b0;
      capsMode    <= 2'b00;
      numMode     <= 2'b00;
      ledArmed    <= 1'b0;
      tailPending <= 1'b0;
      tailSel     <= SEL_TYPE_ID;
    end else begin
      extMode     <= extModeNext;
      capsMode    <= capsNext;
      numMode     <= numNext;
      ledArmed    <= ledNext;
      tailPending <= tailNext;
      tailSel     <= tailSelNext;
    end
  end
endmodule

// File: rtl/kbd_proto_engine.sv
module kbd_proto_engine
  import kbd_proto_pkg::*;
#(
  parameter logic [CODE_W-1:0] TYPE_ID   = 8'h04,
  parameter logic [CODE_W-1:0] LAYOUT_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyValid,
  input  logic [CODE_W-1:0] keyCode,
  input  logic              hostValid,
  input  logic [CODE_W-1:0] hostByte,
  input  logic              queueFull,
  output logic              pushValid,
  output logic [CODE_W-1:0] pushData
);
  dpStrobe_t strobe;
  logic      tailPending;
  logic      ledArmed;

  kbd_proto_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .keyValid(keyValid), .keyCode(keyCode),
    .hostValid(hostValid), .hostByte(hostByte),
    .strobe(strobe), .tailPending(tailPending), .ledArmed(ledArmed)
  );

  kbd_proto_dp #(.TYPE_ID(TYPE_ID), .LAYOUT_ID(LAYOUT_ID)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .keyCode(keyCode), .queueFull(queueFull),
    .pushValid(pushValid), .pushData(pushData)
  );
endmodule

// File: rtl/kbd_proto_chk.sv
module kbd_proto_chk (
  input logic       clk,
  input logic       rstN,
  input logic       keyValid,
  input logic [7:0] keyCode,
  input logic       hostValid,
  input logic [7:0] hostByte,
  input logic       queueFull,
  input logic       pushValid,
  input logic [7:0] pushData,
  input logic       tailPending,
  input logic       ledArmed
);
  // Input assumptions: one strobe per cycle, inputs quiet while a tail byte is due
  a_in_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({keyValid, hostValid}));
  a_in_quiet_tail: assert property (@(posedge clk) disable iff (!rstN)
    tailPending |-> !keyValid && !hostValid);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pushValid);
  a_r2_press_no_release_bit: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && !keyCode[7] |=> !pushValid || !pushData[7]);
  a_r2_release_bit_kept: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && keyCode[7] && keyCode != 8'hE0 |=> !pushValid || pushData[7]);
  a_r4_prefix_silent: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && keyCode == 8'hE0 |=> !pushValid);
  a_r7_reset_header: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && !ledArmed && hostByte == 8'h01 && !queueFull
      |=> pushValid && pushData == 8'hFF && tailPending);
  a_r8_layout_header: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && !ledArmed && hostByte == 8'h07 && !queueFull
      |=> pushValid && pushData == 8'hFE && tailPending);
  a_r7_tail_follows: assert property (@(posedge clk) disable iff (!rstN)
    tailPending && !queueFull |=> pushValid);
  a_r9_led_arg_swallowed: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && ledArmed |=> !pushValid && !ledArmed);
  a_r10_other_host_silent: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && !ledArmed && hostByte != 8'h01 && hostByte != 8'h07
      |=> !pushValid && !tailPending);
  a_r11_full_drops: assert property (@(posedge clk) disable iff (!rstN)
    queueFull |=> !pushValid);
endmodule

bind kbd_proto_engine kbd_proto_chk u_chk (
  .clk(clk), .rstN(rstN),
  .keyValid(keyValid), .keyCode(keyCode),
  .hostValid(hostValid), .hostByte(hostByte),
  .queueFull(queueFull),
  .pushValid(pushValid), .pushData(pushData),
  .tailPending(tailPending), .ledArmed(ledArmed)
);

// File: tb/kbd_proto_engine_tb.sv
module kbd_proto_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CAP_DEPTH  = 2048;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       keyValid = 1'b0;
  logic [7:0] keyCode = '0;
  logic       hostValid = 1'b0;
  logic [7:0] hostByte = '0;
  logic       queueFull = 1'b0;
  logic       pushValid;
  logic [7:0] pushData;

  int nChecks = 0;
  int nFails  = 0;
  int capCount = 0;
  int mark = 0;
  bit finished = 1'b0;
  logic [7:0] capBuf [0:CAP_DEPTH-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_proto_engine u_dut (
    .clk(clk), .rstN(rstN),
    .keyValid(keyValid), .keyCode(keyCode),
    .hostValid(hostValid), .hostByte(hostByte),
    .queueFull(queueFull),
    .pushValid(pushValid), .pushData(pushData)
  );

  always @(negedge clk) begin
    if (rstN && pushValid) begin
      if (capCount < CAP_DEPTH) capBuf[capCount] = pushData;
      capCount = capCount + 1;
    end
  end

  function automatic logic [6:0] normExp(input logic [6:0] i);
    return (i >= 7'h70) ? 7'h00 : (i ^ 7'h2A);
  endfunction

  function automatic logic [6:0] extExp(input logic [6:0] i);
    return i[0] ? 7'((int'(i) + 17) % 128) : 7'h00;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendKey(input logic [7:0] c);
    mark = capCount;
    @(negedge clk);
    keyValid = 1'b1; keyCode = c;
    @(negedge clk);
    keyValid = 1'b0;
    idle(3);
  endtask

  task automatic sendHost(input logic [7:0] b);
    mark = capCount;
    @(negedge clk);
    hostValid = 1'b1; hostByte = b;
    @(negedge clk);
    hostValid = 1'b0;
    idle(3);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic expectOut(input int n, input logic [7:0] e0, input logic [7:0] e1,
                           input string tag);
    int got;
    logic [7:0] g0, g1;
    bit ok;
    got = capCount - mark;
    g0 = (got > 0 && mark < CAP_DEPTH) ? capBuf[mark] : 8'h00;
    g1 = (got > 1 && mark + 1 < CAP_DEPTH) ? capBuf[mark+1] : 8'h00;
    ok = (got == n);
    if (n > 0) ok = ok && (g0 == e0);
    if (n > 1) ok = ok && (g1 == e1);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0d bytes [%02h %02h], expected %0d bytes [%02h %02h]",
               tag, got, g0, g1, n, e0, e1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1: idle after reset
    nChecks++;
    if (pushValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1: pushValid=%b expected 0 after reset", pushValid);
    end
    mark = capCount;
    idle(4);
    expectOut(0, 8'h00, 8'h00, "R1 no spontaneous push");

    // R1: reset clears extended mode and LED-argument flag
    sendKey(8'hE0);
    doReset();
    sendKey(8'h01);
    expectOut(1, 8'h2B, 8'h00, "R1 extended mode cleared");
    sendHost(8'h0E);
    doReset();
    sendHost(8'h01);
    expectOut(2, 8'hFF, 8'h04, "R1 LED flag cleared");

    // R2, R3: sweep of every ordinary scancode through the normal table
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc;
      logic [6:0] e;
      cc = 8'(c);
      if (cc == 8'hE0 || cc == 8'h3A || cc == 8'hBA || cc == 8'h45 || cc == 8'hC5)
        continue;
      e = normExp(cc[6:0]);
      sendKey(cc);
      if (e == 7'h00) expectOut(0, 8'h00, 8'h00, "R3 normal zero entry");
      else            expectOut(1, {cc[7], e}, 8'h00, "R2 normal translation");
    end

    // R4, R3: prefix then alternate table, then back to normal
    for (int i = 0; i < 128; i++) begin
      logic [6:0] ii;
      logic [6:0] e;
      ii = 7'(i);
      if (ii == 7'h3A || ii == 7'h45) continue;
      e = extExp(ii);
      sendKey(8'hE0);
      expectOut(0, 8'h00, 8'h00, "R4 prefix silent");
      sendKey({1'b0, ii});
      if (e == 7'h00) expectOut(0, 8'h00, 8'h00, "R3 alternate zero entry");
      else            expectOut(1, {1'b0, e}, 8'h00, "R4 alternate translation");
      sendKey(8'h01);
      expectOut(1, 8'h2B, 8'h00, "R4 mode clears after one code");
    end
    sendKey(8'hE0);
    sendKey(8'h81);
    expectOut(1, 8'h92, 8'h00, "R4 alternate release keeps bit 7");

    // R5: Caps Lock toggle filtering
    sendKey(8'h3A); expectOut(1, 8'h10, 8'h00, "R5 first press passes");
    sendKey(8'hBA); expectOut(0, 8'h00, 8'h00, "R5 first release dropped");
    sendKey(8'h3A); expectOut(0, 8'h00, 8'h00, "R5 second press dropped");
    sendKey(8'hBA); expectOut(1, 8'h90, 8'h00, "R5 second release passes");
    sendKey(8'h3A); expectOut(1, 8'h10, 8'h00, "R5 cycle repeats");
    sendKey(8'hBA); expectOut(0, 8'h00, 8'h00, "R5 cycle repeats release");

    // R6: Num Lock toggle filtering, independent of Caps state above
    sendKey(8'h45); expectOut(1, 8'h6F, 8'h00, "R6 first press passes");
    sendKey(8'hC5); expectOut(0, 8'h00, 8'h00, "R6 first release dropped");
    sendKey(8'h45); expectOut(0, 8'h00, 8'h00, "R6 second press dropped");
    sendKey(8'hC5); expectOut(1, 8'hEF, 8'h00, "R6 second release passes");

    // R7, R8: host responses
    sendHost(8'h01); expectOut(2, 8'hFF, 8'h04, "R7 reset response");
    sendHost(8'h07); expectOut(2, 8'hFE, 8'h00, "R8 layout response");

    // R9: LED argument swallowed, whatever its value
    sendHost(8'h0E); expectOut(0, 8'h00, 8'h00, "R9 set-LEDs silent");
    sendHost(8'h01); expectOut(0, 8'h00, 8'h00, "R9 argument consumed");
    sendHost(8'h01); expectOut(2, 8'hFF, 8'h04, "R9 parser back to commands");
    sendHost(8'h0E);
    sendHost(8'h07); expectOut(0, 8'h00, 8'h00, "R9 layout value consumed");

    // R10: other host bytes ignored
    for (int b = 0; b < 256; b += 17) begin
      logic [7:0] bb;
      bb = 8'(b);
      if (bb == 8'h01 || bb == 8'h07 || bb == 8'h0E) continue;
      sendHost(bb);
      expectOut(0, 8'h00, 8'h00, "R10 unknown host byte");
    end
    sendKey(8'h01); expectOut(1, 8'h2B, 8'h00, "R10 state untouched");

    // R11: full queue drops bytes
    queueFull = 1'b1;
    sendKey(8'h01); expectOut(0, 8'h00, 8'h00, "R11 key dropped when full");
    sendHost(8'h01); expectOut(0, 8'h00, 8'h00, "R11 response dropped when full");
    queueFull = 1'b0;
    idle(2);
    mark = capCount;
    idle(3);
    expectOut(0, 8'h00, 8'h00, "R11 no late push");
    mark = capCount;
    @(negedge clk);
    hostValid = 1'b1; hostByte = 8'h07;
    @(negedge clk);
    hostValid = 1'b0; queueFull = 1'b1;
    @(negedge clk);
    queueFull = 1'b0;
    idle(3);
    expectOut(1, 8'hFE, 8'h00, "R11 tail byte dropped alone");

    finishRun();
  end
endmodule